// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the instruction fetch address for a small core with 14-bit instructions. It holds a 13-bit program counter that can address 8K instruction words. Its upper five bits can never be read. They are loaded only from a separate upper-address latch, which software writes through its own strobe. The low eight bits of the counter are visible as a data byte and can also be written as one. On such a write, the whole latch is merged in above the written byte.

A jump or call carries an 11-bit literal. The two page bits above the literal come from the top two bits of the latch. Calls and interrupt entries push a return address onto an eight-entry, 13-bit return stack, and returns pop it. The stack is a circular buffer: it never flags overflow or underflow, and it silently overwrites its oldest entries. Without a control strobe the counter advances by one on each instruction-cycle strobe. It holds when no strobe is present.

The surrounding core decodes instructions and asserts at most one meaningful command per cycle. When several strobes coincide, a fixed priority picks exactly one of them.

Top module: `fetch_addr_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the fetch address is 0x0000, the upper latch holds 0, and the stack pointer stands at entry 0, with all entries reading 0.
- R2: A cycle with only the step strobe loads fetch address + 1, and 0x1FFF wraps to 0x0000.
- R3: A cycle with no command strobe leaves the fetch address unchanged, and a latch write alone does not change it either.
- R4: A low-byte write loads PC[12:8] from latch[4:0] and PC[7:0] from the written byte, in the same update. The previous PC plays no part, so a byte produced by an add that overflowed 0xFF carries nothing into the upper bits. `pc_lo_o` always equals PC[7:0].
- R5: A jump loads PC[10:0] from the literal and PC[12:11] from latch[4:3].
- R6: A call pushes the address of the instruction after the call, that is PC + 1 modulo 8K. It then loads the same target a jump would.
- R7: A return pops the most recent stack entry into all 13 PC bits, whatever value the latch holds.
- R8: An interrupt request pushes the current PC unchanged and loads the vector address 0x004.
- R9: The stack holds 8 entries and is circular. The ninth push overwrites the first entry, and the tenth push overwrites the second. After nine pushes, nine pops return the ninth value down to the second, and then the ninth value again.
- R10: A latch write takes effect from the next cycle. Any command in the same cycle uses the old latch value.
- R11: Command priority, from highest to lowest, is interrupt, return, call, jump, low-byte write, step. Only the winning command takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Advance to the next sequential address |
| lo_wr_i | input | 1 | Write the low PC byte |
| lo_wdata_i | input | 8 | Byte for the low PC write |
| hi_wr_i | input | 1 | Write the upper-address latch |
| hi_wdata_i | input | 5 | Value for the upper-address latch |
| jump_i | input | 1 | Jump to the paged literal |
| call_i | input | 1 | Call the paged literal and push the return address |
| ret_i | input | 1 | Return: pop the stack into the PC |
| lit_i | input | 11 | Branch literal from the instruction |
| irq_i | input | 1 | Interrupt branch to the vector address |
| fetch_addr_o | output | 13 | Current instruction fetch address |
| pc_lo_o | output | 8 | Readable low PC byte |

## Verification
A wrong counter or latch value appears at `fetch_addr_o` in the cycle right after the command that uses it. A latch error stays hidden until the next low-byte write, jump or call merges the latch in. A wrong stack pointer or a corrupted entry shows only when a later return lands on an unexpected address. That can be many cycles after the bad push. The long call chains and random return sequences therefore compare every return target against a model of the circular buffer.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // One winning command per cycle, after priority arbitration.
  typedef enum logic [2:0] {
    CMD_HOLD = 3'd0,
    CMD_STEP = 3'd1,
    CMD_LOWR = 3'd2,
    CMD_JUMP = 3'd3,
    CMD_CALL = 3'd4,
    CMD_RET  = 3'd5,
    CMD_IRQ  = 3'd6
  } pc_cmd_e;
endpackage

// File: rtl/pcs_arb.sv
module pcs_arb
  import pcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    step_i,
  input  logic    lo_wr_i,
  input  logic    jump_i,
  input  logic    call_i,
  input  logic    ret_i,
  input  logic    irq_i,
  output pc_cmd_e cmd_o
);
  always_comb begin
    if (irq_i)        cmd_o = CMD_IRQ;
    else if (ret_i)   cmd_o = CMD_RET;
    else if (call_i)  cmd_o = CMD_CALL;
    else if (jump_i)  cmd_o = CMD_JUMP;
    else if (lo_wr_i) cmd_o = CMD_LOWR;
    else if (step_i)  cmd_o = CMD_STEP;
    else              cmd_o = CMD_HOLD;
  end

  // R11
  irq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |-> cmd_o == CMD_IRQ);
  // R11
  ret_over_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_i && ret_i) |-> cmd_o == CMD_RET);
endmodule

// File: rtl/pcs_latch.sv
module pcs_latch #(
  parameter int HI_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [HI_W-1:0] wdata_i,
  output logic [HI_W-1:0] latch_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    latch_o <= '0;
    else if (wr_i) latch_o <= wdata_i;
  end

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(latch_o));
  // R10
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> latch_o == $past(wdata_i));
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_data_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_inc;
  logic [PTR_W-1:0] ptr_dec;
  logic [W-1:0]     ent_q [DEPTH];

  // Pointer arithmetic that wraps at DEPTH, whether or not DEPTH is a power of two.
  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] wrap_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - PTR_W'(1);
  endfunction

  assign ptr_inc = wrap_inc(ptr_q);
  assign ptr_dec = wrap_dec(ptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (push_i) ptr_q <= ptr_inc;
    else if (pop_i)  ptr_q <= ptr_dec;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                 ent_q[g] <= '0;
      else if (push_i && ptr_q == PTR_W'(g))      ent_q[g] <= push_data_i;
    end
  end

  assign top_data_o = ent_q[ptr_dec];

  // R9
  ptr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> ptr_q == wrap_inc($past(ptr_q)));
  // R9
  ptr_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> ptr_q == wrap_dec($past(ptr_q)));
  // R9
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));
endmodule

// File: rtl/pcs_core.sv
module pcs_core
  import pcs_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LO_W  = 8,
  parameter int LIT_W = 11,
  parameter int VEC   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pc_cmd_e              cmd_i,
  input  logic [PC_W-LO_W-1:0] latch_i,
  input  logic [LIT_W-1:0]     lit_i,
  input  logic [LO_W-1:0]      lo_wdata_i,
  input  logic [PC_W-1:0]      pop_data_i,
  output logic [PC_W-1:0]      pc_o,
  output logic                 push_o,
  output logic                 pop_o,
  output logic [PC_W-1:0]      push_data_o
);
  localparam int HI_W   = PC_W - LO_W;
  localparam int PAGE_W = PC_W - LIT_W;
  localparam logic [PC_W-1:0] VEC_ADDR = PC_W'(VEC);

  logic [PC_W-1:0] pc_d;

  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] a);
    return a + PC_W'(1);
  endfunction

  function automatic logic [PC_W-1:0] paged_target(input logic [HI_W-1:0] lat,
                                                   input logic [LIT_W-1:0] lit);
    return {lat[HI_W-1 -: PAGE_W], lit};
  endfunction

  function automatic logic [PC_W-1:0] byte_target(input logic [HI_W-1:0] lat,
                                                  input logic [LO_W-1:0] b);
    return {lat, b};
  endfunction

  always_comb begin
    unique case (cmd_i)
      CMD_IRQ:  pc_d = VEC_ADDR;
      CMD_RET:  pc_d = pop_data_i;
      CMD_CALL: pc_d = paged_target(latch_i, lit_i);
      CMD_JUMP: pc_d = paged_target(latch_i, lit_i);
      CMD_LOWR: pc_d = byte_target(latch_i, lo_wdata_i);
      CMD_STEP: pc_d = seq_next(pc_o);
      default:  pc_d = pc_o;
    endcase
  end

  assign push_o      = (cmd_i == CMD_CALL) || (cmd_i == CMD_IRQ);
  assign pop_o       = (cmd_i == CMD_RET);
  assign push_data_o = (cmd_i == CMD_IRQ) ? pc_o : seq_next(pc_o);

  always_ff @(posedge clk) begin
    if (!rst_n) pc_o <= '0;
    else        pc_o <= pc_d;
  end

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == CMD_STEP |=> pc_o == $past(pc_o) + PC_W'(1));
  // R3
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == CMD_HOLD |=> $stable(pc_o));
  // R4
  lowr_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == CMD_LOWR |=> pc_o[LO_W-1:0] == $past(lo_wdata_i));
  // R5
  jump_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == CMD_JUMP |=> pc_o[LIT_W-1:0] == $past(lit_i));
  // R8
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == CMD_IRQ |=> pc_o == VEC_ADDR);
  // R7
  ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == CMD_RET |=> pc_o == $past(pop_data_i));
endmodule

// File: rtl/fetch_addr_unit.sv
module fetch_addr_unit
  import pcs_pkg::*;
#(
  parameter int PC_W        = 13,
  parameter int LO_W        = 8,
  parameter int LIT_W       = 11,
  parameter int STACK_DEPTH = 8,
  parameter int VEC         = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_i,
  input  logic                 lo_wr_i,
  input  logic [LO_W-1:0]      lo_wdata_i,
  input  logic                 hi_wr_i,
  input  logic [PC_W-LO_W-1:0] hi_wdata_i,
  input  logic                 jump_i,
  input  logic                 call_i,
  input  logic                 ret_i,
  input  logic [LIT_W-1:0]     lit_i,
  input  logic                 irq_i,
  output logic [PC_W-1:0]      fetch_addr_o,
  output logic [LO_W-1:0]      pc_lo_o
);
  localparam int HI_W = PC_W - LO_W;

  pc_cmd_e         cmd;
  logic [HI_W-1:0] latch;
  logic            push;
  logic            pop;
  logic [PC_W-1:0] push_data;
  logic [PC_W-1:0] pop_data;

  pcs_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step_i),
    .lo_wr_i (lo_wr_i),
    .jump_i  (jump_i),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .irq_i   (irq_i),
    .cmd_o   (cmd)
  );

  pcs_latch #(.HI_W(HI_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (hi_wr_i),
    .wdata_i (hi_wdata_i),
    .latch_o (latch)
  );

  pcs_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (push_data),
    .top_data_o  (pop_data)
  );

  pcs_core #(.PC_W(PC_W), .LO_W(LO_W), .LIT_W(LIT_W), .VEC(VEC)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd),
    .latch_i     (latch),
    .lit_i       (lit_i),
    .lo_wdata_i  (lo_wdata_i),
    .pop_data_i  (pop_data),
    .pc_o        (fetch_addr_o),
    .push_o      (push),
    .pop_o       (pop),
    .push_data_o (push_data)
  );

  assign pc_lo_o = fetch_addr_o[LO_W-1:0];

  // R1
  reset_pc_chk: assert property (@(posedge clk)
    !rst_n |=> fetch_addr_o == '0);
  // R4
  lo_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr_i && !step_i && !jump_i && !call_i && !ret_i && !irq_i
      |=> fetch_addr_o[PC_W-1:LO_W] == $past(latch));
endmodule

// File: tb/fetch_addr_unit_tb_top.sv
module fetch_addr_unit_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        step_i, lo_wr_i, hi_wr_i, jump_i, call_i, ret_i, irq_i;
  logic [7:0]  lo_wdata_i;
  logic [4:0]  hi_wdata_i;
  logic [10:0] lit_i;
  logic [12:0] fetch_addr_o;
  logic [7:0]  pc_lo_o;

  fetch_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .lo_wr_i(lo_wr_i),
    .lo_wdata_i(lo_wdata_i), .hi_wr_i(hi_wr_i), .hi_wdata_i(hi_wdata_i),
    .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i), .lit_i(lit_i),
    .irq_i(irq_i), .fetch_addr_o(fetch_addr_o), .pc_lo_o(pc_lo_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference model state
  logic [12:0] m_pc;
  logic [4:0]  m_lat;
  logic [12:0] m_stk [8];
  int          m_sp;

  function automatic logic [12:0] exp_page(input logic [4:0] lat, input logic [10:0] l);
    return (13'(lat >> 3) << 11) | 13'(l);
  endfunction

  function automatic logic [12:0] exp_byte(input logic [4:0] lat, input logic [7:0] b);
    return (13'(lat) << 8) | 13'(b);
  endfunction

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_push(input logic [12:0] v);
    m_stk[m_sp] = v;
    m_sp = (m_sp + 1) % 8;
  endtask

  task automatic drive(input string tag, input logic st, input logic lw, input logic [7:0] ld,
                       input logic hw, input logic [4:0] hd, input logic jp, input logic cl,
                       input logic rt, input logic [10:0] l, input logic iq);
    @(negedge clk);
    step_i = st; lo_wr_i = lw; lo_wdata_i = ld; hi_wr_i = hw; hi_wdata_i = hd;
    jump_i = jp; call_i = cl; ret_i = rt; lit_i = l; irq_i = iq;
    @(posedge clk);
    #1;
    if (iq) begin
      model_push(m_pc);
      m_pc = 13'h004;
    end else if (rt) begin
      m_sp = (m_sp + 7) % 8;
      m_pc = m_stk[m_sp];
    end else if (cl) begin
      model_push(m_pc + 13'd1);
      m_pc = exp_page(m_lat, l);
    end else if (jp) begin
      m_pc = exp_page(m_lat, l);
    end else if (lw) begin
      m_pc = exp_byte(m_lat, ld);
    end else if (st) begin
      m_pc = m_pc + 13'd1;
    end
    if (hw) m_lat = hd;
    check(tag, fetch_addr_o, m_pc);
    check({tag, " low byte"}, {5'b0, pc_lo_o}, {5'b0, m_pc[7:0]});
  endtask

  task automatic do_step(input string t); drive(t, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic do_hold(input string t); drive(t, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic do_lo(input string t, input logic [7:0] d); drive(t, 0, 1, d, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic do_hi(input string t, input logic [4:0] d); drive(t, 0, 0, 0, 1, d, 0, 0, 0, 0, 0); endtask
  task automatic do_jump(input string t, input logic [10:0] l); drive(t, 0, 0, 0, 0, 0, 1, 0, 0, l, 0); endtask
  task automatic do_call(input string t, input logic [10:0] l); drive(t, 0, 0, 0, 0, 0, 0, 1, 0, l, 0); endtask
  task automatic do_ret(input string t); drive(t, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0); endtask
  task automatic do_irq(input string t); drive(t, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    step_i = 0; lo_wr_i = 0; lo_wdata_i = 0; hi_wr_i = 0; hi_wdata_i = 0;
    jump_i = 0; call_i = 0; ret_i = 0; lit_i = 0; irq_i = 0;
    m_pc = 0; m_lat = 0; m_sp = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset address", fetch_addr_o, 13'h0000);
    rst_n = 1'b1;
    do_hold("R1 first cycle after reset");
    // An immediate return at reset pops entry 7, which must read 0.
    do_ret("R1 reset stack empty");

    // R2: sequential stepping and wrap at the top of the space
    do_step("R2 step");
    do_step("R2 step");
    do_hi("R3 latch write alone", 5'h1F);
    do_lo("R4 byte write to top", 8'hFF);
    do_step("R2 wrap 1FFF to 0");
    // R3: hold without a strobe
    do_hold("R3 hold");
    do_hold("R3 hold");

    // R4: an add result that overflowed yields no carry into the upper bits
    do_hi("R3 latch write alone", 5'h02);
    do_lo("R4 byte write", 8'hF0);
    do_lo("R4 no carry from add", 8'h10);

    // R10: a simultaneous latch write and byte write use the old latch
    drive("R10 old latch used", 0, 1, 8'h33, 1, 5'h07, 0, 0, 0, 0, 0);
    do_lo("R10 new latch visible", 8'h44);
    drive("R10 latch write with step", 1, 0, 0, 1, 5'h19, 0, 0, 0, 0, 0);

    // R5: paged jump (latch bits 4:3 = 11)
    do_jump("R5 jump page 3", 11'h123);
    do_hi("R3 latch write alone", 5'h0B);
    do_jump("R5 jump page 1", 11'h7FF);

    // R6/R7: call then return, with the latch changed before the return
    do_call("R6 call", 11'h055);
    do_hi("R3 latch write alone", 5'h1F);
    do_step("R2 step in callee");
    do_ret("R7 return ignores latch");

    // R8: interrupt pushes the current address and vectors to 0x004
    do_irq("R8 interrupt vector");
    do_step("R2 step in handler");
    do_ret("R8 return from interrupt");

    // R9: nine nested calls, then nine returns
    for (int k = 0; k < 9; k++) do_call("R9 nested call", 11'(16 * k + 3));
    for (int k = 0; k < 9; k++) do_ret("R9 circular return");

    // R11: priority among coinciding strobes
    drive("R11 all strobes: interrupt wins", 1, 1, 8'hAA, 0, 0, 1, 1, 1, 11'h111, 1);
    drive("R11 return over call", 0, 0, 0, 0, 0, 0, 1, 1, 11'h222, 0);
    drive("R11 call over jump", 0, 0, 0, 0, 0, 1, 1, 0, 11'h333, 0);
    drive("R11 jump over byte write", 1, 1, 8'h5A, 0, 0, 1, 0, 0, 11'h444, 0);
    drive("R11 byte write over step", 1, 1, 8'hC3, 0, 0, 0, 0, 0, 0, 0);

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom % 100;
      drive("R2-mix random",
            r < 60,
            ($urandom % 10) == 0, 8'($urandom),
            ($urandom % 6) == 0, 5'($urandom),
            ($urandom % 14) == 0,
            ($urandom % 14) == 0,
            ($urandom % 14) == 0,
            11'($urandom),
            ($urandom % 40) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule